// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit controller core. Each cycle it combines an accumulator operand with a second operand under a 4-bit operation code and drives the 8-bit result combinationally. When the flag-write strobe is high, a registered 5-bit status word captures the new condition flags on the rising clock edge. The operations are add, increment, decrement, compare, AND, OR, XOR, complement, add-stored-carry, and shifts left or right by one or four places.

The sign flag is kept in inverted sense: it is set when the result is non-negative. Overflow is the disagreement between the carry into the top bit and the carry out of it. Compare leaves the accumulator value on the result port and only produces flags. It computes them by adding the operand to the two's complement of the accumulator.

Next to the datapath sits a 6-bit register for indirect scratchpad addressing. It can be loaded, stepped up or stepped down. A step changes only the low three bits, so the address stays inside its group of eight.

Top module: `alu8_status`

## Requirements
- R1: The status word holds sign at bit 0, carry at bit 1, zero at bit 2, overflow at bit 3 and interrupt enable at bit 4. Reset sets it to 0. It changes only on a clock edge with `flag_we_i` high and a flag-setting opcode (0 to 12). A flag-setting update first clears bits 3:0 and then sets them from the new operation.
- R2: Bit 4 (interrupt enable) is never changed by any ALU operation.
- R3: Sign is written as the inverse of bit 7 of the flag-producing 8-bit value. Zero is written as 1 exactly when that value is 0.
- R4: Opcode 0 adds A+B, opcode 1 adds A+1, and opcode 12 adds A plus the stored carry bit. The result is the low 8 bits of the sum. Carry is set when the unsigned sum exceeds 255. Overflow is the carry out of bits 6:0 XOR the carry out of bit 7.
- R5: Opcode 2 decrements by adding 0xFF to A. Carry and overflow follow the R4 rules for that addition.
- R6: Opcode 3 (compare) drives A unchanged on the result port. It sets the flags from the 9-bit value (~A+1) plus B, where the 9-bit value (~A+1) equals 256 when A is 0. Carry is bit 8 of that sum, sign and zero come from its low 8 bits, and overflow follows R4.
- R7: Opcodes 4, 5 and 6 give A AND B, A OR B and A XOR B. Opcode 7 gives ~A. All four set sign and zero only, and leave carry and overflow at 0.
- R8: Opcode 8 shifts A left by 1, opcode 9 shifts right by 1, opcode 10 shifts left by 4 and opcode 11 shifts right by 4. Vacated bits fill with zeros. Carry and overflow are 0.
- R9: Opcodes 13 to 15 pass A to the result port and leave the status word unchanged, even with `flag_we_i` high.
- R10: The indirect address resets to 0. With `isa_load_i` high it loads `isa_data_i`, and load has priority over stepping. With `isa_step_i` set to 01 it increments bits 2:0, and with 10 it decrements them. Bits 2:0 wrap modulo 8 and bits 5:3 are preserved. A step value of 00 or 11 holds the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 8 | Accumulator operand A |
| opb_i | input | 8 | Second operand B |
| op_i | input | 4 | Operation code |
| flag_we_i | input | 1 | Status write strobe |
| isa_load_i | input | 1 | Load indirect address |
| isa_data_i | input | 6 | Indirect address load value |
| isa_step_i | input | 2 | 01 increment, 10 decrement |
| result_o | output | 8 | Combinational result |
| status_o | output | 5 | Registered status word |
| isa_o | output | 6 | Indirect scratchpad address |

## Verification
The hardest case to reach is compare with A equal to zero. There the complemented term becomes 256, so carry is forced and overflow appears with no signed wrap of the operands. Random operands seldom hit this, so directed steps drive compare with A=0 against B values of zero and non-zero. Link depends on the carry left by the previous operation, so the stimulus precedes link steps with adds chosen to leave carry both set and clear. Index wrap at both ends of a group of eight is also forced directly.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int STAT_W = 5;
  localparam int F_SGN  = 0;
  localparam int F_CRY  = 1;
  localparam int F_ZER  = 2;
  localparam int F_OVF  = 3;
  localparam int F_IEN  = 4;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_INC = 4'd1;
  localparam logic [3:0] OP_DEC = 4'd2;
  localparam logic [3:0] OP_CMP = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_COM = 4'd7;
  localparam logic [3:0] OP_SL1 = 4'd8;
  localparam logic [3:0] OP_SR1 = 4'd9;
  localparam logic [3:0] OP_SL4 = 4'd10;
  localparam logic [3:0] OP_SR4 = 4'd11;
  localparam logic [3:0] OP_LNK = 4'd12;

  localparam logic [1:0] STEP_UP = 2'b01;
  localparam logic [1:0] STEP_DN = 2'b10;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W:0]   a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W:0]   full;
  logic [W-1:0] low;

  always_comb begin
    full    = a_i + {1'b0, b_i};
    low     = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]};
    sum_o   = full[W-1:0];
    carry_o = full[W];
    ovf_o   = low[W-1] ^ full[W];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W    = 8,
  parameter int WIDE = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  res_o = ~a_i;
      OP_SL1:  res_o = a_i << 1;
      OP_SR1:  res_o = a_i >> 1;
      OP_SL4:  res_o = a_i << WIDE;
      OP_SR4:  res_o = a_i >> WIDE;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu8_isa.sv
module alu8_isa
  import alu8_pkg::*;
#(
  parameter int IW   = 6,
  parameter int GRPW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [IW-1:0] data_i,
  input  logic [1:0]    step_i,
  output logic [IW-1:0] isa_o
);
  logic [GRPW-1:0] low_nx;

  always_comb begin
    unique case (step_i)
      STEP_UP: low_nx = isa_o[GRPW-1:0] + 1'b1;
      STEP_DN: low_nx = isa_o[GRPW-1:0] - 1'b1;
      default: low_nx = isa_o[GRPW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         isa_o <= '0;
    else if (load_i) isa_o <= data_i;
    else             isa_o <= {isa_o[IW-1:GRPW], low_nx};
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int W    = 8,
  parameter int IW   = 6,
  parameter int GRPW = 3,
  parameter int WIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      acc_i,
  input  logic [W-1:0]      opb_i,
  input  logic [3:0]        op_i,
  input  logic              flag_we_i,
  input  logic              isa_load_i,
  input  logic [IW-1:0]     isa_data_i,
  input  logic [1:0]        isa_step_i,
  output logic [W-1:0]      result_o,
  output logic [STAT_W-1:0] status_o,
  output logic [IW-1:0]     isa_o
);
  logic [W:0]   add_a;
  logic [W-1:0] add_b;
  logic [W-1:0] add_sum;
  logic         add_c;
  logic         add_v;
  logic [W-1:0] log_res;
  logic         is_arith;
  logic         is_cmp;
  logic         sets_flags;
  logic [W-1:0] flag_val;
  logic [3:0]   new_flags;

  always_comb begin
    add_a    = {1'b0, acc_i};
    add_b    = opb_i;
    is_arith = 1'b1;
    is_cmp   = 1'b0;
    unique case (op_i)
      OP_ADD: add_b = opb_i;
      OP_INC: add_b = W'(1);
      OP_DEC: add_b = '1;
      OP_CMP: begin
        add_a  = {1'b0, ~acc_i} + 1'b1;
        is_cmp = 1'b1;
      end
      OP_LNK: add_b = W'(status_o[F_CRY]);
      default: is_arith = 1'b0;
    endcase
    sets_flags = (op_i <= OP_LNK);
  end

  alu8_adder #(.W(W)) u_add (
    .a_i     (add_a),
    .b_i     (add_b),
    .sum_o   (add_sum),
    .carry_o (add_c),
    .ovf_o   (add_v)
  );

  alu8_logic #(.W(W), .WIDE(WIDE)) u_log (
    .a_i   (acc_i),
    .b_i   (opb_i),
    .op_i  (op_i),
    .res_o (log_res)
  );

  always_comb begin
    if (is_cmp)        result_o = acc_i;
    else if (is_arith) result_o = add_sum;
    else               result_o = log_res;
    flag_val = (is_arith) ? add_sum : log_res;
    new_flags[F_SGN] = ~flag_val[W-1];
    new_flags[F_ZER] = (flag_val == '0);
    new_flags[F_CRY] = is_arith & add_c;
    new_flags[F_OVF] = is_arith & add_v;
  end

  always_ff @(posedge clk) begin
    if (rst)
      status_o <= '0;
    else if (flag_we_i && sets_flags)
      status_o <= {status_o[F_IEN], new_flags};
  end

  alu8_isa #(.IW(IW), .GRPW(GRPW)) u_isa (
    .clk    (clk),
    .rst    (rst),
    .load_i (isa_load_i),
    .data_i (isa_data_i),
    .step_i (isa_step_i),
    .isa_o  (isa_o)
  );
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu8_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [7:0]        acc_i,
  input logic [3:0]        op_i,
  input logic              flag_we_i,
  input logic              isa_load_i,
  input logic [1:0]        isa_step_i,
  input logic [7:0]        result_o,
  input logic [STAT_W-1:0] status_o,
  input logic [5:0]        isa_o
);
  p_ie_hold_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(status_o[F_IEN]));

  p_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    !flag_we_i |=> $stable(status_o));

  p_unused_op_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_LNK) |=> $stable(status_o));

  p_cmp_acc_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP) |-> (result_o == acc_i));

  p_logic_cv_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i >= OP_AND && op_i <= OP_COM)
      |=> (!status_o[F_CRY] && !status_o[F_OVF]));

  p_shift_cv_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i >= OP_SL1 && op_i <= OP_SR4)
      |=> (!status_o[F_CRY] && !status_o[F_OVF]));

  p_sign_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i != OP_CMP && op_i <= OP_LNK)
      |=> (status_o[F_SGN] == ~$past(result_o[7]) &&
           status_o[F_ZER] == ($past(result_o) == 8'h00)));

  p_isa_group_r10: assert property (@(posedge clk) disable iff (rst)
    (!isa_load_i) |=> (isa_o[5:3] == $past(isa_o[5:3])));

  p_isa_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!isa_load_i && (isa_step_i == 2'b00 || isa_step_i == 2'b11))
      |=> $stable(isa_o));
endmodule

bind alu8_status alu8_status_chk u_chk (.*);

// File: tb/tb_alu8_status.sv
`timescale 1ns/1ps
module tb_alu8_status;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] acc, opb;
  logic [3:0] op;
  logic       we;
  logic       ld;
  logic [5:0] ldat;
  logic [1:0] step;
  logic [7:0] result;
  logic [4:0] status;
  logic [5:0] isa;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_stat;
  logic [5:0] exp_isa;
  bit done = 0;

  always #10 clk = ~clk;

  alu8_status dut (
    .clk(clk), .rst(rst), .acc_i(acc), .opb_i(opb), .op_i(op),
    .flag_we_i(we), .isa_load_i(ld), .isa_data_i(ldat), .isa_step_i(step),
    .result_o(result), .status_o(status), .isa_o(isa)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns {valid, O, Z, C, S, result[7:0]}
  function automatic logic [12:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic [3:0] o, input logic cin);
    logic [8:0] n, m, s;
    logic [7:0] r, fv;
    logic c, v, ar, c7;
    n = {1'b0, a}; m = {1'b0, b}; ar = 1'b1;
    case (o)
      4'd0: ;
      4'd1: m = 9'd1;
      4'd2: m = 9'hFF;
      4'd3: n = 9'd256 - {1'b0, a};
      4'd12: m = {8'd0, cin};
      default: ar = 1'b0;
    endcase
    s  = n + m;
    c7 = ({1'b0, n[6:0]} + {1'b0, m[6:0]}) > 8'd127;
    c  = ar && (s > 9'd255);
    v  = ar && (c7 != (s > 9'd255));
    case (o)
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = ~a;
      4'd8: r = {a[6:0], 1'b0};
      4'd9: r = {1'b0, a[7:1]};
      4'd10: r = {a[3:0], 4'b0};
      4'd11: r = {4'b0, a[7:4]};
      4'd3: r = a;
      default: r = ar ? s[7:0] : a;
    endcase
    fv = ar ? s[7:0] : r;
    model = {(o <= 4'd12), v, (fv == 8'd0), c, ~fv[7], r};
  endfunction

  function automatic string rtag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd12: rtag = "R4";
      4'd2: rtag = "R5";
      4'd3: rtag = "R6";
      4'd4, 4'd5, 4'd6, 4'd7: rtag = "R7";
      4'd8, 4'd9, 4'd10, 4'd11: rtag = "R8";
      default: rtag = "R9";
    endcase
  endfunction

  task automatic alu_step(input logic [7:0] a, input logic [7:0] b,
                          input logic [3:0] o, input logic w);
    logic [12:0] mo;
    @(negedge clk);
    acc = a; opb = b; op = o; we = w;
    #2;
    mo = model(a, b, o, exp_stat[1]);
    chk({rtag(o), " result"}, {24'd0, result}, {24'd0, mo[7:0]});
    if (w && mo[12]) exp_stat = {exp_stat[4], mo[11:8]};
    @(posedge clk); #2;
    chk({rtag(o), "/R1/R2/R3 status"}, {27'd0, status}, {27'd0, exp_stat});
  endtask

  task automatic isa_step(input logic l, input logic [5:0] d, input logic [1:0] s);
    @(negedge clk);
    ld = l; ldat = d; step = s; we = 1'b0;
    if (l) exp_isa = d;
    else if (s == 2'b01) exp_isa = {exp_isa[5:3], exp_isa[2:0] + 3'd1};
    else if (s == 2'b10) exp_isa = {exp_isa[5:3], exp_isa[2:0] - 3'd1};
    @(posedge clk); #2;
    chk("R10 isa", {26'd0, isa}, {26'd0, exp_isa});
    @(negedge clk); ld = 1'b0; step = 2'b00;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    rst = 1'b1; acc = 8'h00; opb = 8'h00; op = 4'd0; we = 1'b0;
    ld = 1'b0; ldat = 6'd0; step = 2'b00;
    exp_stat = 5'd0; exp_isa = 6'd0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset status", {27'd0, status}, 32'd0);
    chk("R10 reset isa", {26'd0, isa}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // directed corners
    alu_step(8'h00, 8'h00, 4'd3, 1'b1);  // R6 compare A=0: carry and overflow forced
    alu_step(8'h00, 8'h5A, 4'd3, 1'b1);  // R6
    alu_step(8'h10, 8'h10, 4'd3, 1'b1);  // R6 equal operands
    alu_step(8'h7F, 8'h01, 4'd0, 1'b1);  // R4 signed overflow
    alu_step(8'hFF, 8'h01, 4'd0, 1'b1);  // R4 carry, zero
    alu_step(8'h41, 8'h00, 4'd12, 1'b1); // R4 link with carry set
    alu_step(8'h41, 8'h00, 4'd12, 1'b1); // R4 link with carry clear
    alu_step(8'h00, 8'h00, 4'd2, 1'b1);  // R5 decrement from zero
    alu_step(8'h80, 8'h00, 4'd2, 1'b1);  // R5 decrement overflow
    alu_step(8'hFF, 8'h01, 4'd0, 1'b1);  // set carry
    alu_step(8'h0F, 8'hF0, 4'd4, 1'b1);  // R7 and -> zero, carry cleared
    alu_step(8'h96, 8'h00, 4'd10, 1'b1); // R8 shift left 4
    alu_step(8'h96, 8'h00, 4'd11, 1'b1); // R8 shift right 4
    alu_step(8'hFF, 8'h01, 4'd0, 1'b1);  // set flags
    alu_step(8'h12, 8'h34, 4'd13, 1'b1); // R9 unused opcode, status holds
    alu_step(8'h00, 8'h00, 4'd15, 1'b1); // R9
    alu_step(8'h00, 8'h00, 4'd0, 1'b0);  // R1 no write strobe

    // R10 index register
    isa_step(1'b1, 6'o27, 2'b00);
    isa_step(1'b0, 6'd0, 2'b01);   // 27 -> 20 wrap
    isa_step(1'b0, 6'd0, 2'b10);   // 20 -> 27 wrap
    isa_step(1'b0, 6'd0, 2'b11);   // hold
    isa_step(1'b1, 6'o52, 2'b01);  // load wins over step
    isa_step(1'b0, 6'd0, 2'b10);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, b;
      logic [3:0] o;
      logic w;
      a = 8'($urandom);
      b = 8'($urandom);
      o = 4'($urandom % 16);
      w = ($urandom % 4) != 0;
      alu_step(a, b, o, w);
    end
    for (int i = 0; i < 60; i++) begin
      isa_step(($urandom % 5) == 0, 6'($urandom), 2'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule